// File: doc/BRIEF.md
# Cache Line Permission Tracker

This block holds the per-line state of a small direct-mapped cache and decides, in the cycle a CPU-side request is presented, whether the request can be served from the line. Each line carries a tag and a five-bit status word in which the permission to read is kept apart from the valid bit. A line with an exclusive (upgrade) miss in flight therefore stays resident and keeps its tag, but reads to it no longer hit. A later read cannot then return data that the pending write is about to make stale.

Misses are tracked in a small table of outstanding block addresses. A miss to a block already in the table joins the existing entry instead of opening a second one. A miss that finds the table full is held off by dropping the ready signal. Writebacks that miss are sent to a write buffer and never use the table. A full-block write that misses installs the line at once, because no fetch is needed. Fill responses rewrite the line status and release the matching table entry in the same cycle. A shared fill that answers an exclusive miss is reported as an error.

Top module: `cache_perm_tracker`

## Requirements
- R1: Status bit positions are valid = bit 0, writable = bit 1, readable = bit 2, dirty = bit 3, referenced = bit 4. After reset every line reads as 5'h00.
- R2: A request that is not exclusive (req_write, req_excl and req_is_wb all low) hits only when the line holds the request's tag with both valid and readable set. A valid line without readable does not hit.
- R3: An exclusive request (req_write or req_excl) hits only when the tag matches with valid and writable set. Every hit sets referenced, and a write hit also sets dirty.
- R4: An exclusive miss to a line that holds the request's tag with valid set and writable clear clears readable, keeps valid, and allocates a table entry. A later read to that block then merges.
- R5: A miss with no matching table entry and a free slot raises mshr_alloc for one cycle. alloc_addr carries the request address with its low log2(LINE_BYTES) bits forced to zero.
- R6: A miss whose block-aligned address matches a valid table entry raises req_merge and does not raise mshr_alloc, even when the table is full.
- R7: A miss that needs a new entry while all entries are valid sees req_ready low. No alloc, hit or merge is signalled, and the line status is unchanged.
- R8: A non-shared fill writes the line as exactly 5'h07 (valid, readable, writable) with the fill's tag, and frees the matching entry in the same cycle.
- R9: A shared fill writes exactly 5'h05 (valid, readable). fill_err is high in the fill cycle if the matching entry was allocated by an exclusive request.
- R10: A writeback (req_is_wb) hits when the line is valid, writable and the tag matches, and then sets dirty and referenced. Otherwise it raises wbuf_alloc and never mshr_alloc.
- R11: A full-block write (req_write and req_full_blk) that misses with no matching entry hits at once and installs the line as 5'h1D (valid, readable, dirty, referenced), without using the table.
- R12: A request whose line index equals that of a fill in the same cycle sees req_ready low and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address; also selects the line shown on line_status |
| req_write | input | 1 | Request is a store |
| req_excl | input | 1 | Request needs exclusive ownership |
| req_full_blk | input | 1 | Store covers the whole block |
| req_is_wb | input | 1 | Request is a writeback |
| fill_valid | input | 1 | Fill response present |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_shared | input | 1 | Fill grants a shared copy only |
| req_ready | output | 1 | Request accepted this cycle |
| req_hit | output | 1 | Request served by the line |
| req_merge | output | 1 | Miss joined an outstanding entry |
| mshr_alloc | output | 1 | New outstanding-miss entry opened |
| wbuf_alloc | output | 1 | Writeback miss sent to the write buffer |
| alloc_addr | output | ADDR_W | Block-aligned address of the request |
| line_status | output | 5 | Status of the line indexed by req_addr, before this cycle's update |
| fill_err | output | 1 | Shared fill answered an exclusive miss |

## Verification
The bench builds the block with its default values: 64-byte blocks, 16 lines and a 4-entry miss table. These are small enough for the bench to sweep every line index through reset, install and read-back. They also let the table be filled to capacity with a handful of misses, so the full stall, merge-while-full, slot reuse after a fill, and fill/request clashes on one index are all reached in a short directed run. Expected status words are built arithmetically from the bit positions in R1.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

   localparam int unsigned STAT_W = 5;
   localparam int unsigned ST_V   = 0;
   localparam int unsigned ST_W   = 1;
   localparam int unsigned ST_R   = 2;
   localparam int unsigned ST_D   = 3;
   localparam int unsigned ST_REF = 4;

   typedef logic [STAT_W-1:0] line_stat_t;

   function automatic line_stat_t stat_bit(input int unsigned pos);
      line_stat_t s;
      s = '0;
      s[pos] = 1'b1;
      return s;
   endfunction

   // Status written by a fill: shared fills withhold write permission.
   function automatic line_stat_t fill_stat(input logic shared);
      line_stat_t s;
      s = stat_bit(ST_V) | stat_bit(ST_R);
      if (!shared) s = s | stat_bit(ST_W);
      return s;
   endfunction

endpackage

// File: rtl/cpt_line_array.sv
module cpt_line_array
   import cpt_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned TAG_W     = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output line_stat_t       rd_stat,
   input  logic             a_we,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [TAG_W-1:0] a_tag,
   input  line_stat_t       a_stat,
   input  logic             b_we,
   input  logic [IDX_W-1:0] b_idx,
   input  logic [TAG_W-1:0] b_tag,
   input  line_stat_t       b_stat
);

   logic [TAG_W-1:0] tag_arr [NUM_LINES];
   line_stat_t       st_arr  [NUM_LINES];

   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         logic [TAG_W-1:0] t_q;
         line_stat_t       s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               t_q <= '0;
               s_q <= '0;
            end else if (a_we && a_idx == IDX_W'(l)) begin
               t_q <= a_tag;
               s_q <= a_stat;
            end else if (b_we && b_idx == IDX_W'(l)) begin
               t_q <= b_tag;
               s_q <= b_stat;
            end
         end
         assign tag_arr[l] = t_q;
         assign st_arr[l]  = s_q;
      end
   endgenerate

   assign rd_tag  = tag_arr[rd_idx];
   assign rd_stat = st_arr[rd_idx];

endmodule

// File: rtl/cpt_miss_table.sv
module cpt_miss_table #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned BLK_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] lk_blk,
   output logic             lk_hit,
   input  logic [BLK_W-1:0] fl_blk,
   input  logic             free_en,
   output logic             fl_hit,
   output logic             fl_excl,
   input  logic             alloc_en,
   input  logic [BLK_W-1:0] alloc_blk,
   input  logic             alloc_excl,
   output logic             full
);

   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] excl_q;
   logic [DEPTH-1:0] lk_vec;
   logic [DEPTH-1:0] fl_vec;
   logic [DEPTH-1:0] pick;

   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic             v_q;
         logic             x_q;
         logic [BLK_W-1:0] b_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               x_q <= 1'b0;
               b_q <= '0;
            end else if (alloc_en && pick[e]) begin
               v_q <= 1'b1;
               x_q <= alloc_excl;
               b_q <= alloc_blk;
            end else if (free_en && fl_vec[e]) begin
               v_q <= 1'b0;
            end
         end
         assign vld[e]    = v_q;
         assign excl_q[e] = x_q;
         assign lk_vec[e] = v_q && (b_q == lk_blk);
         assign fl_vec[e] = v_q && (b_q == fl_blk);
      end
   endgenerate

   assign lk_hit  = |lk_vec;
   assign fl_hit  = |fl_vec;
   assign fl_excl = |(fl_vec & excl_q);
   assign full    = &vld;

endmodule

// File: rtl/cpt_decide.sv
module cpt_decide
   import cpt_pkg::*;
(
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       req_excl,
   input  logic       req_full_blk,
   input  logic       req_is_wb,
   input  logic       tag_eq,
   input  line_stat_t cur_stat,
   input  logic       miss_match,
   input  logic       miss_full,
   input  logic       fill_clash,
   output logic       ready,
   output logic       hit,
   output logic       merge,
   output logic       alloc,
   output logic       wbuf,
   output logic       st_we,
   output line_stat_t st_new
);

   logic need_ex;
   logic tag_hit;
   logic perm_ok;
   logic hit_c, merge_c, alloc_c, wbuf_c, we_c;

   assign need_ex = req_write | req_excl | req_is_wb;
   assign tag_hit = cur_stat[ST_V] && tag_eq;
   assign perm_ok = need_ex ? cur_stat[ST_W] : cur_stat[ST_R];

   always_comb begin
      ready   = 1'b1;
      hit_c   = 1'b0;
      merge_c = 1'b0;
      alloc_c = 1'b0;
      wbuf_c  = 1'b0;
      we_c    = 1'b0;
      st_new  = cur_stat;
      if (fill_clash) begin
         ready = 1'b0;
      end else if (req_is_wb) begin
         if (tag_hit && cur_stat[ST_W]) begin
            hit_c  = 1'b1;
            we_c   = 1'b1;
            st_new = cur_stat | stat_bit(ST_REF) | stat_bit(ST_D);
         end else begin
            wbuf_c = 1'b1;
         end
      end else if (tag_hit && perm_ok) begin
         hit_c  = 1'b1;
         we_c   = 1'b1;
         st_new = cur_stat | stat_bit(ST_REF);
         if (req_write) st_new = st_new | stat_bit(ST_D);
      end else if (miss_match) begin
         merge_c = 1'b1;
      end else if (req_write && req_full_blk) begin
         hit_c  = 1'b1;
         we_c   = 1'b1;
         st_new = stat_bit(ST_V) | stat_bit(ST_R) | stat_bit(ST_D) | stat_bit(ST_REF);
      end else if (miss_full) begin
         ready = 1'b0;
      end else begin
         alloc_c = 1'b1;
         if (need_ex && tag_hit) begin
            we_c   = 1'b1;
            st_new = cur_stat & ~stat_bit(ST_R);
         end
      end
   end

   assign hit   = req_valid & hit_c;
   assign merge = req_valid & merge_c;
   assign alloc = req_valid & alloc_c;
   assign wbuf  = req_valid & wbuf_c;
   assign st_we = req_valid & we_c;

endmodule

// File: rtl/cache_perm_tracker.sv
module cache_perm_tracker
   import cpt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned NUM_LINES  = 16,
   parameter int unsigned MISS_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_excl,
   input  logic              req_full_blk,
   input  logic              req_is_wb,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_shared,
   output logic              req_ready,
   output logic              req_hit,
   output logic              req_merge,
   output logic              mshr_alloc,
   output logic              wbuf_alloc,
   output logic [ADDR_W-1:0] alloc_addr,
   output logic [4:0]        line_status,
   output logic              fill_err
);

   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W = $clog2(NUM_LINES);
   localparam int unsigned BLK_W = ADDR_W - OFF_W;
   localparam int unsigned TAG_W = BLK_W - IDX_W;

   initial begin
      assert (LINE_BYTES >= 2 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two");
      assert (NUM_LINES >= 2 && (NUM_LINES & (NUM_LINES - 1)) == 0)
         else $error("NUM_LINES must be a power of two");
      assert (MISS_DEPTH >= 1) else $error("MISS_DEPTH must be at least 1");
      assert (ADDR_W > OFF_W + IDX_W) else $error("ADDR_W too narrow for tag");
   end

   logic [IDX_W-1:0] req_idx, fill_idx;
   logic [TAG_W-1:0] req_tag, fill_tag, cur_tag;
   logic [BLK_W-1:0] req_blk, fill_blk;
   line_stat_t       cur_stat, new_stat;
   logic             st_we, miss_match, miss_full, fl_hit, fl_excl, fill_clash;

   assign req_idx  = req_addr[OFF_W +: IDX_W];
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign req_blk  = req_addr[ADDR_W-1 -: BLK_W];
   assign fill_idx = fill_addr[OFF_W +: IDX_W];
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
   assign fill_blk = fill_addr[ADDR_W-1 -: BLK_W];
   assign fill_clash = fill_valid && (fill_idx == req_idx);

   cpt_line_array #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W),
      .TAG_W     (TAG_W)
   ) i_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_idx),
      .rd_tag  (cur_tag),
      .rd_stat (cur_stat),
      .a_we    (fill_valid),
      .a_idx   (fill_idx),
      .a_tag   (fill_tag),
      .a_stat  (fill_stat(fill_shared)),
      .b_we    (st_we),
      .b_idx   (req_idx),
      .b_tag   (req_tag),
      .b_stat  (new_stat)
   );

   cpt_miss_table #(
      .DEPTH (MISS_DEPTH),
      .BLK_W (BLK_W)
   ) i_misses (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_blk     (req_blk),
      .lk_hit     (miss_match),
      .fl_blk     (fill_blk),
      .free_en    (fill_valid),
      .fl_hit     (fl_hit),
      .fl_excl    (fl_excl),
      .alloc_en   (mshr_alloc),
      .alloc_blk  (req_blk),
      .alloc_excl (req_write | req_excl),
      .full       (miss_full)
   );

   cpt_decide i_decide (
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_excl     (req_excl),
      .req_full_blk (req_full_blk),
      .req_is_wb    (req_is_wb),
      .tag_eq       (cur_tag == req_tag),
      .cur_stat     (cur_stat),
      .miss_match   (miss_match),
      .miss_full    (miss_full),
      .fill_clash   (fill_clash),
      .ready        (req_ready),
      .hit          (req_hit),
      .merge        (req_merge),
      .alloc        (mshr_alloc),
      .wbuf         (wbuf_alloc),
      .st_we        (st_we),
      .st_new       (new_stat)
   );

   assign alloc_addr  = {req_blk, {OFF_W{1'b0}}};
   assign line_status = cur_stat;
   assign fill_err    = fill_valid && fill_shared && fl_hit && fl_excl;

endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned NUM_LINES  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              req_excl,
   input logic              req_full_blk,
   input logic              req_is_wb,
   input logic              fill_valid,
   input logic [ADDR_W-1:0] fill_addr,
   input logic              fill_shared,
   input logic              req_ready,
   input logic              req_hit,
   input logic              req_merge,
   input logic              mshr_alloc,
   input logic              wbuf_alloc,
   input logic [ADDR_W-1:0] alloc_addr,
   input logic [4:0]        line_status,
   input logic              fill_err
);

   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W = $clog2(NUM_LINES);

   AST_READ_HIT_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hit && !req_write && !req_excl && !req_is_wb) |-> (line_status[0] && line_status[2])); // R2

   AST_EXCL_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hit && (req_excl || req_is_wb || (req_write && !req_full_blk))) |-> (line_status[0] && line_status[1])); // R3

   AST_ALLOC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mshr_alloc |-> (alloc_addr[OFF_W-1:0] == '0 && alloc_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W])); // R5

   AST_MERGE_NOT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      !(mshr_alloc && req_merge)); // R6

   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> !(mshr_alloc || req_hit || req_merge || wbuf_alloc)); // R7

   AST_FILL_EXCL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !fill_shared && !req_valid && fill_addr[OFF_W +: IDX_W] == req_addr[OFF_W +: IDX_W])
      |=> (req_addr[OFF_W +: IDX_W] != $past(fill_addr[OFF_W +: IDX_W]) || line_status == 5'h07)); // R8

   AST_FILL_ERR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_err |-> (fill_valid && fill_shared)); // R9

   AST_WB_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      wbuf_alloc |-> (req_is_wb && !mshr_alloc)); // R10

endmodule

bind cache_perm_tracker cpt_checker #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .NUM_LINES  (NUM_LINES)
) i_cpt_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .req_write    (req_write),
   .req_excl     (req_excl),
   .req_full_blk (req_full_blk),
   .req_is_wb    (req_is_wb),
   .fill_valid   (fill_valid),
   .fill_addr    (fill_addr),
   .fill_shared  (fill_shared),
   .req_ready    (req_ready),
   .req_hit      (req_hit),
   .req_merge    (req_merge),
   .mshr_alloc   (mshr_alloc),
   .wbuf_alloc   (wbuf_alloc),
   .alloc_addr   (alloc_addr),
   .line_status  (line_status),
   .fill_err     (fill_err)
);

// File: tb/test_cache_perm_tracker.sv
`timescale 1ns/1ps
module test_cache_perm_tracker;

   localparam int unsigned AW = 32;
   localparam logic [4:0] S_V = 5'h01, S_W = 5'h02, S_R = 5'h04, S_D = 5'h08, S_F = 5'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
   logic          req_full_blk = 1'b0, req_is_wb = 1'b0;
   logic [AW-1:0] req_addr = '0, fill_addr = '0;
   logic          fill_valid = 1'b0, fill_shared = 1'b0;
   logic          req_ready, req_hit, req_merge, mshr_alloc, wbuf_alloc, fill_err;
   logic [AW-1:0] alloc_addr;
   logic [4:0]    line_status;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cache_perm_tracker i_cache_perm_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_excl(req_excl), .req_full_blk(req_full_blk),
      .req_is_wb(req_is_wb), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_shared(fill_shared), .req_ready(req_ready), .req_hit(req_hit),
      .req_merge(req_merge), .mshr_alloc(mshr_alloc), .wbuf_alloc(wbuf_alloc),
      .alloc_addr(alloc_addr), .line_status(line_status), .fill_err(fill_err)
   );

   function automatic logic [AW-1:0] addr_a(input int i);
      return 32'h0001_0000 | AW'(i << 6) | AW'((i * 7) % 64);
   endfunction

   function automatic logic [AW-1:0] addr_b(input int i);
      return 32'h0040_0000 | AW'(i << 6) | AW'(5);
   endfunction

   task automatic chk(input string req, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_excl = 1'b0;
      req_full_blk = 1'b0; req_is_wb = 1'b0; fill_valid = 1'b0; fill_shared = 1'b0;
   endtask

   task automatic drive(input logic [AW-1:0] a, input logic wr, input logic ex,
                        input logic fb, input logic wb);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_excl = ex;
      req_full_blk = fb; req_is_wb = wb;
      #1;
   endtask

   task automatic fill(input logic [AW-1:0] a, input logic sh);
      fill_valid = 1'b1; fill_addr = a; fill_shared = sh;
      #1;
   endtask

   task automatic peek(input string req, input logic [AW-1:0] a, input logic [4:0] exp);
      req_valid = 1'b0; req_addr = a;
      #1;
      chk(req, "line status", AW'(line_status), AW'(exp));
      step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1: every line empty after reset
      for (int i = 0; i < 16; i++) peek("R1", addr_a(i), 5'h00);

      // R5: four read misses open four entries
      for (int i = 0; i < 4; i++) begin
         drive(addr_a(i), 0, 0, 0, 0);
         chk("R5", "ready", AW'(req_ready), 1);
         chk("R5", "hit", AW'(req_hit), 0);
         chk("R5", "alloc", AW'(mshr_alloc), 1);
         chk("R5", "alloc_addr", alloc_addr, addr_a(i) & ~AW'(63));
         step();
      end

      // R6: second miss to an outstanding block merges
      drive(addr_a(1) | AW'(60), 0, 0, 0, 0);
      chk("R6", "merge", AW'(req_merge), 1);
      chk("R6", "alloc", AW'(mshr_alloc), 0);
      step();

      // R7: table full, new block stalls
      drive(addr_a(5), 0, 0, 0, 0);
      chk("R7", "ready", AW'(req_ready), 0);
      chk("R7", "alloc", AW'(mshr_alloc), 0);
      step();
      peek("R7", addr_a(5), 5'h00);

      // R8: exclusive fill, then read and write hits (R2, R3)
      fill(addr_a(0), 0);
      chk("R8", "fill_err", AW'(fill_err), 0);
      step();
      peek("R8", addr_a(0), S_V | S_R | S_W);
      drive(addr_a(0), 0, 0, 0, 0);
      chk("R2", "read hit", AW'(req_hit), 1);
      step();
      peek("R3", addr_a(0), S_V | S_R | S_W | S_F);
      drive(addr_a(0), 1, 0, 0, 0);
      chk("R3", "write hit", AW'(req_hit), 1);
      step();
      peek("R3", addr_a(0), S_V | S_R | S_W | S_F | S_D);
      drive(addr_a(5), 0, 0, 0, 0);
      chk("R8", "freed slot reused", AW'(mshr_alloc), 1);
      step();

      // R9: shared fill, read hit, then upgrade miss (R4)
      fill(addr_a(1), 1);
      chk("R9", "fill_err non-excl", AW'(fill_err), 0);
      step();
      peek("R9", addr_a(1), S_V | S_R);
      drive(addr_a(1), 0, 0, 0, 0);
      chk("R2", "shared read hit", AW'(req_hit), 1);
      step();
      drive(addr_a(1), 1, 0, 0, 0);
      chk("R4", "upgrade hit", AW'(req_hit), 0);
      chk("R4", "upgrade alloc", AW'(mshr_alloc), 1);
      step();
      peek("R4", addr_a(1), S_V | S_F);
      drive(addr_a(1), 0, 0, 0, 0);
      chk("R4", "read while upgrading hit", AW'(req_hit), 0);
      chk("R6", "merge while full", AW'(req_merge), 1);
      chk("R6", "ready while full", AW'(req_ready), 1);
      step();
      fill(addr_a(1), 1);
      chk("R9", "fill_err excl", AW'(fill_err), 1);
      step();
      peek("R9", addr_a(1), S_V | S_R);

      // R10: writebacks
      drive(addr_a(0), 0, 0, 0, 1);
      chk("R10", "wb hit", AW'(req_hit), 1);
      chk("R10", "wb hit no wbuf", AW'(wbuf_alloc), 0);
      step();
      drive(addr_a(9), 0, 0, 0, 1);
      chk("R10", "wb miss wbuf", AW'(wbuf_alloc), 1);
      chk("R10", "wb miss no alloc", AW'(mshr_alloc), 0);
      step();
      peek("R10", addr_a(9), 5'h00);

      // R11: full-block write install
      drive(addr_a(12), 1, 0, 1, 0);
      chk("R11", "fbw hit", AW'(req_hit), 1);
      chk("R11", "fbw alloc", AW'(mshr_alloc), 0);
      step();
      peek("R11", addr_a(12), S_V | S_R | S_D | S_F);

      // R12: fill and request on one index
      fill(addr_a(2), 0);
      drive(addr_a(2) ^ AW'(3), 0, 0, 0, 0);
      chk("R12", "ready", AW'(req_ready), 0);
      chk("R12", "hit", AW'(req_hit), 0);
      step();
      peek("R12", addr_a(2), S_V | S_R | S_W);

      // R2: same index, other tag misses
      drive(addr_a(0) | AW'(1 << 10), 0, 0, 0, 0);
      chk("R2", "tag mismatch hit", AW'(req_hit), 0);
      chk("R5", "tag mismatch alloc", AW'(mshr_alloc), 1);
      chk("R5", "alloc_addr", alloc_addr, (addr_a(0) | AW'(1 << 10)) & ~AW'(63));
      step();
      peek("R2", addr_a(0), S_V | S_R | S_W | S_F | S_D);

      // R11 / R2 sweep over every line
      for (int i = 0; i < 16; i++) begin
         drive(addr_b(i), 1, 0, 1, 0);
         chk("R11", "sweep fbw hit", AW'(req_hit), 1);
         step();
         peek("R11", addr_b(i), S_V | S_R | S_D | S_F);
         drive(addr_b(i), 0, 0, 0, 0);
         chk("R2", "sweep read hit", AW'(req_hit), 1);
         step();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule